// File: doc/BRIEF.md
# Dual 8-bit PWM/Toggle Timer

This block holds two 8-bit counters that either run as two separate channels or chain into one 16-bit counter. A 2-bit mode input selects how they are arranged. Each channel can flip its output pin each time its count reaches the period value, or drive a pulse-width waveform by comparing its count with a duty value. The low and high halves each raise their own one-cycle interrupt pulse.

The counters advance only on cycles where the `tick` clock-enable is high. Period and duty values are loaded through a small write port into staging registers. The counters pick up those values at the next rollover, so a running waveform never changes shape in the middle of a period.

In mode 3 the chained 16-bit counter still toggles the high pin, while its low byte also drives a PWM waveform on the low pin.

Top module: `dual_pwm_timer`

## Requirements
- R1: While reset is asserted and afterwards until the first tick, `out_lo`, `out_hi`, `irq_lo` and `irq_hi` are 0. All period and duty registers reset to 0.
- R2: Counters change only on clock edges where `tick` is 1. When `tick` is 0, outputs keep their values for any number of clocks.
- R3: In mode 0 each half counts 0..P on its own, where P is its active period. On the tick at count P it returns to 0 and flips its pin, so the pin flips every P+1 ticks.
- R4: In mode 1 each half counts 0..P as in R3. Its pin is 1 while the count is below the active duty value and 0 otherwise.
- R5: For a PWM output, a duty of 0 gives a constant 0 and a duty of 255 gives a constant 1.
- R6: In modes 2 and 3 the halves form one 16-bit counter with period {period_hi, period_lo}. `out_hi` flips on the tick at which the 16-bit count equals that period, and the count then returns to 0. In mode 2, `out_lo` flips on each tick where the low count byte equals period_lo, but only when `lo_tog_en` is 1; otherwise it stays 0.
- R7: In mode 3 `out_hi` behaves as in R6, and `out_lo` is the PWM of the low count byte against duty_lo, using the rule of R4 and R5.
- R8: `irq_lo` and `irq_hi` are one-cycle pulses. Each is raised in the cycle after the tick on which its half matched its period. In modes 2 and 3, the low half matches when the low byte equals period_lo.
- R9: Writes go to staging registers. A half's active period and duty are loaded from staging on that half's rollover, or on a mode change. A write in the middle of a period does not alter the waveform.
- R10: On the clock after `mode` changes, both counters and both toggle states are 0, and no interrupt is raised.
- R11: The write port decodes `wr_addr` as follows: 0 is period_lo, 1 is period_hi, 2 is duty_lo, 3 is duty_hi. The write takes effect on a clock edge where `wr_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable |
| mode | input | 2 | Arrangement: 0 two toggles, 1 two PWMs, 2 16-bit toggle, 3 16-bit toggle plus low PWM |
| lo_tog_en | input | 1 | Enables the low-byte toggle in mode 2 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 8 | Write data |
| out_lo | output | 1 | Low-half pin |
| out_hi | output | 1 | High-half pin |
| irq_lo | output | 1 | Low-half interrupt pulse |
| irq_hi | output | 1 | High-half interrupt pulse |

## Verification
A vector table runs each mode with differing periods and tick counts. Tick counts that stop just before, on, and just after a rollover show whether the period is P+1 ticks or off by one. In mode 2, a 16-bit period of 257 checked at 257 and 258 ticks shows whether the carry into the high byte is handled correctly. PWM vectors use duty 0, duty 255 and a count past the duty value to show the compare direction and both fixed levels. Directed tests then cover idle clocks without a tick, a duty write in mid-period, the interrupt pulse width, the mode-2 low toggle and a mode switch.

// File: rtl/dual_pwm_timer.sv
module dual_pwm_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [1:0]   mode,
  input  logic         lo_tog_en,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  output logic         out_lo,
  output logic         out_hi,
  output logic         irq_lo,
  output logic         irq_hi
);
  localparam int CW = 2 * W;

  logic [1:0]   mode_q;
  logic [W-1:0] st_per_lo, st_per_hi, st_dut_lo, st_dut_hi;
  logic [W-1:0] ac_per_lo, ac_per_hi, ac_dut_lo, ac_dut_hi;
  logic [W-1:0] cnt_lo, cnt_hi;
  logic         tog_lo, tog_hi;

  wire          chg    = mode != mode_q;
  wire          wide   = mode[1];
  wire [CW-1:0] cnt_w  = {cnt_hi, cnt_lo};
  wire          lo_hit = cnt_lo == ac_per_lo;
  wire          hi_hit = cnt_hi == ac_per_hi;
  wire          w_hit  = lo_hit && hi_hit;
  wire          lo_evt = tick && lo_hit;
  wire          roll_lo = tick && (wide ? w_hit : lo_hit);
  wire          roll_hi = tick && (wide ? w_hit : hi_hit);
  wire          lo_flip = lo_evt && (mode == 2'd0 || (mode == 2'd2 && lo_tog_en));
  wire          pw_lo  = (ac_dut_lo == {W{1'b1}}) || (cnt_lo < ac_dut_lo);
  wire          pw_hi  = (ac_dut_hi == {W{1'b1}}) || (cnt_hi < ac_dut_hi);

  assign out_lo = mode[0] ? pw_lo : tog_lo;
  assign out_hi = (mode == 2'd1) ? pw_hi : tog_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_per_lo <= '0; st_per_hi <= '0; st_dut_lo <= '0; st_dut_hi <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        2'd0: st_per_lo <= wr_data;
        2'd1: st_per_hi <= wr_data;
        2'd2: st_dut_lo <= wr_data;
        default: st_dut_hi <= wr_data;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ac_per_lo <= '0; ac_dut_lo <= '0; ac_per_hi <= '0; ac_dut_hi <= '0;
    end else begin
      if (chg || roll_lo) begin
        ac_per_lo <= st_per_lo;
        ac_dut_lo <= st_dut_lo;
      end
      if (chg || roll_hi) begin
        ac_per_hi <= st_per_hi;
        ac_dut_hi <= st_dut_hi;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 2'd0;
      cnt_lo <= '0;
      cnt_hi <= '0;
      tog_lo <= 1'b0;
      tog_hi <= 1'b0;
      irq_lo <= 1'b0;
      irq_hi <= 1'b0;
    end else begin
      mode_q <= mode;
      irq_lo <= !chg && lo_evt;
      irq_hi <= !chg && roll_hi;
      if (chg) begin
        cnt_lo <= '0;
        cnt_hi <= '0;
        tog_lo <= 1'b0;
        tog_hi <= 1'b0;
      end else if (tick) begin
        if (wide) begin
          {cnt_hi, cnt_lo} <= w_hit ? '0 : cnt_w + 1'b1;
        end else begin
          cnt_lo <= lo_hit ? '0 : cnt_lo + 1'b1;
          cnt_hi <= hi_hit ? '0 : cnt_hi + 1'b1;
        end
        tog_lo <= tog_lo ^ lo_flip;
        tog_hi <= tog_hi ^ roll_hi;
      end
    end
  end

  assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !chg) |=> ($stable(cnt_lo) && $stable(cnt_hi)));

  assert_mode_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    chg |=> (cnt_lo == '0 && cnt_hi == '0 && !tog_lo && !tog_hi && !irq_lo && !irq_hi));

  assert_irq_after_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_lo || irq_hi) |-> $past(tick));

  assert_irq_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_hi && !$past(tick, 2)) |=> !irq_hi);

  assert_pwm_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && ac_dut_hi == '0) |-> !out_hi);

  assert_pwm_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[0] && ac_dut_lo == {W{1'b1}}) |-> out_lo);

  assert_duty_buffered_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!chg && !roll_lo) |=> $stable(ac_dut_lo));

  assert_split_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide && !chg && tick && lo_hit) |=> (cnt_lo == '0));
endmodule

// File: tb/tb_dual_pwm_timer.sv
module tb_dual_pwm_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [1:0] mode = 2'd0;
  logic       lo_tog_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       out_lo, out_hi, irq_lo, irq_hi;
  int         checks = 0;
  int         errors = 0;

  always #4 clk = ~clk;

  dual_pwm_timer dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode), .lo_tog_en(lo_tog_en),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .out_lo(out_lo), .out_hi(out_hi), .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  // mode, per_lo, per_hi, duty_lo, duty_hi, ticks, exp out_lo, exp out_hi
  localparam logic [51:0] VEC [0:10] = '{
    {2'd0, 8'd2, 8'd4, 8'd0, 8'd0,   16'd7,   1'b0, 1'b1}, // R3
    {2'd0, 8'd0, 8'd1, 8'd0, 8'd0,   16'd3,   1'b1, 1'b1}, // R3
    {2'd1, 8'd9, 8'd9, 8'd4, 8'd0,   16'd3,   1'b1, 1'b0}, // R4 R5
    {2'd1, 8'd9, 8'd9, 8'd4, 8'd255, 16'd5,   1'b0, 1'b1}, // R4 R5
    {2'd1, 8'd3, 8'd3, 8'd2, 8'd3,   16'd5,   1'b1, 1'b1}, // R4
    {2'd2, 8'd3, 8'd0, 8'd0, 8'd0,   16'd4,   1'b0, 1'b1}, // R6
    {2'd2, 8'd1, 8'd1, 8'd0, 8'd0,   16'd257, 1'b0, 1'b0}, // R6
    {2'd2, 8'd1, 8'd1, 8'd0, 8'd0,   16'd258, 1'b0, 1'b1}, // R6
    {2'd3, 8'd9, 8'd0, 8'd4, 8'd0,   16'd3,   1'b1, 1'b0}, // R7
    {2'd3, 8'd9, 8'd0, 8'd4, 8'd0,   16'd10,  1'b1, 1'b1}, // R7
    {2'd3, 8'd9, 8'd0, 8'd4, 8'd0,   16'd7,   1'b0, 1'b0}  // R7
  };

  task automatic check(input logic got, input logic exp, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0b expected %0b", what, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic setup(input logic [1:0] m, input logic [7:0] pl, input logic [7:0] ph,
                       input logic [7:0] dl, input logic [7:0] dh);
    wr(2'd0, pl); wr(2'd1, ph); wr(2'd2, dl); wr(2'd3, dh);
    mode = m ^ 2'd1;
    @(negedge clk);
    mode = m;
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_lo, 1'b0, "R1 out_lo in reset");
    check(irq_hi, 1'b0, "R1 irq_hi in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(out_hi, 1'b0, "R1 out_hi after reset");
    check(irq_lo, 1'b0, "R1 irq_lo after reset");

    for (int i = 0; i < 11; i++) begin
      setup(VEC[i][51:50], VEC[i][49:42], VEC[i][41:34], VEC[i][33:26], VEC[i][25:18]);
      ticks(int'(VEC[i][17:2]));
      check(out_lo, VEC[i][1], $sformatf("R11 vector %0d out_lo", i));
      check(out_hi, VEC[i][0], $sformatf("R11 vector %0d out_hi", i));
    end

    // R2: idle clocks leave the PWM count unchanged
    setup(2'd1, 8'd9, 8'd9, 8'd4, 8'd0);
    ticks(3);
    repeat (20) @(negedge clk);
    check(out_lo, 1'b1, "R2 out_lo after idle clocks");
    ticks(1);
    check(out_lo, 1'b0, "R2 out_lo after one more tick");

    // R9: duty write mid-period waits for rollover
    setup(2'd1, 8'd9, 8'd9, 8'd4, 8'd0);
    ticks(5);
    wr(2'd2, 8'd8);
    check(out_lo, 1'b0, "R9 duty unchanged before rollover");
    ticks(10);
    check(out_lo, 1'b1, "R9 new duty after rollover");

    // R8: interrupt pulse width
    setup(2'd0, 8'd2, 8'd4, 8'd0, 8'd0);
    ticks(2);
    check(irq_lo, 1'b0, "R8 no irq before match");
    ticks(1);
    check(irq_lo, 1'b1, "R8 irq_lo after match");
    check(irq_hi, 1'b0, "R8 irq_hi quiet");
    @(negedge clk);
    check(irq_lo, 1'b0, "R8 irq_lo single cycle");
    check(out_lo, 1'b1, "R3 out_lo toggled");

    // R6: low toggle enabled in mode 2
    lo_tog_en = 1'b1;
    setup(2'd2, 8'd2, 8'd1, 8'd0, 8'd0);
    ticks(3);
    check(out_lo, 1'b1, "R6 low byte toggle enabled");
    check(out_hi, 1'b0, "R6 high not yet");
    lo_tog_en = 1'b0;

    // R10: mode change clears
    setup(2'd0, 8'd0, 8'd0, 8'd0, 8'd0);
    ticks(1);
    check(out_lo, 1'b1, "R10 pre-change out_lo");
    check(out_hi, 1'b1, "R10 pre-change out_hi");
    mode = 2'd2;
    @(negedge clk);
    check(out_lo, 1'b0, "R10 out_lo cleared");
    check(out_hi, 1'b0, "R10 out_hi cleared");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule